// File: doc/BRIEF.md
# I2C FIFO Threshold and Drain Event Logic

This block holds the byte-wide transmit and receive FIFOs of an I2C controller and decides when the processor has to service them. The processor programs a threshold for each direction and a transfer byte count. The block compares the FIFO fill levels and the number of bytes still owed against those thresholds. From that comparison it raises four request events: transmit-ready, transmit-drain, receive-ready and receive-drain.

The drain events cover the tail of a transfer. That is the case where the bytes that remain can no longer make up a full threshold, so the ordinary ready event would never fire. With the drain events, the last partial block is still moved. The serial bit engine sits on the other side of the FIFOs: it pops transmit bytes and pushes received bytes, and each byte it moves lowers the remaining-byte counter. The counter is loaded when a transfer starts.

Top module: `i2c_fifo_events`

## Requirements
- R1: After reset both FIFOs are empty, both levels read 0, all four events and `rx_underflow` are low, and the remaining-byte counter is 0.
- R2: A cycle with `cfg_wr` high captures `cfg_word`. Bits [5:0] hold the transmit threshold minus 1 and bits [13:8] hold the receive threshold minus 1, so the threshold is the field plus 1. In the same write, bit 6 empties the transmit FIFO and bit 14 empties the receive FIFO at the next clock edge.
- R3: Each FIFO returns bytes in the order they were pushed. A push into a full FIFO (depth `8 << DEPTH_CODE`) is dropped and the level stays at the depth.
- R4: `cpu_rx_data` carries the oldest received byte in bits [7:0]. A `cpu_rx_pop` while the receive FIFO is empty returns 0 and raises `rx_underflow` in that same cycle.
- R5: `xfer_start` loads the 16-bit `cnt_value` into the remaining-byte counter. The counter drops by one for each byte moved on the bus, meaning an `eng_tx_pop` on a non-empty transmit FIFO or an `eng_rx_push`. It holds at 0, and a start in the same cycle as a move wins.
- R6: The transmit-ready condition is: transmit level below the threshold, and owed bytes at least the threshold. Owed bytes are the remaining count minus the transmit level, floored at 0.
- R7: The transmit-drain condition is: owed bytes non-zero but below the threshold, and transmit level below the threshold. It never coincides with transmit-ready.
- R8: The receive-ready condition is: receive level at or above the threshold.
- R9: The receive-drain condition is: a transfer has been started, the remaining count is 0, and the receive level is non-zero but below the threshold.
- R10: Each event is a one-cycle pulse in the first cycle its condition holds. It fires again only after the condition has gone false, which happens when the FIFO is serviced.
- R11: `depth_code` reports n, where the FIFO depth is `8 << n` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the buffer configuration word |
| cfg_word | input | 16 | Threshold fields and FIFO clear bits |
| cnt_value | input | 16 | Transfer byte count |
| xfer_start | input | 1 | Transfer start; loads the counter |
| cpu_tx_push | input | 1 | Processor writes a transmit byte |
| cpu_tx_data | input | 8 | Transmit byte from the processor |
| cpu_rx_pop | input | 1 | Processor reads a receive byte |
| cpu_rx_data | output | 8 | Oldest receive byte, 0 when empty |
| rx_underflow | output | 1 | Read from an empty receive FIFO |
| eng_tx_pop | input | 1 | Bit engine takes a transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_push | input | 1 | Bit engine delivers a receive byte |
| eng_rx_data | input | 8 | Received byte from the bit engine |
| tx_level | output | $clog2(DEPTH+1) | Transmit FIFO fill level |
| rx_level | output | $clog2(DEPTH+1) | Receive FIFO fill level |
| tx_ready_ev | output | 1 | Transmit-ready pulse |
| tx_drain_ev | output | 1 | Transmit-drain pulse |
| rx_ready_ev | output | 1 | Receive-ready pulse |
| rx_drain_ev | output | 1 | Receive-drain pulse |
| depth_code | output | 3 | Encoded FIFO depth n |

## Verification
The transmit flow runs a count of ten with a threshold of four. The first refill, taken while six bytes are still owed, must produce exactly one ready pulse and no drain. The second, with two bytes owed, must produce exactly one drain pulse and no ready. Once every owed byte is queued, nothing must fire, and this separates the owed-byte arithmetic from a plain level compare. On the receive side, a full threshold block followed by a two-byte tail shows receive-ready and receive-drain firing apart. A short count of three, with the threshold switched from four to two, shows the count and the threshold fields steering the choice between drain and ready. Clear bits, overflow of a full FIFO and a read of an empty FIFO cover the boundary cases.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;
  localparam int CNT_W   = 16;
  localparam int FIELD_W = 6;
  localparam int THR_W   = FIELD_W + 1;

  localparam int EV_TXR = 0;
  localparam int EV_TXD = 1;
  localparam int EV_RXR = 2;
  localparam int EV_RXD = 3;
  localparam int EV_N   = 4;

  // threshold stored as value minus one
  function automatic logic [THR_W-1:0] thr_of(input logic [FIELD_W-1:0] f);
    return {1'b0, f} + THR_W'(1);
  endfunction

  // bytes the processor still has to queue: remaining minus queued, floor 0
  function automatic logic [CNT_W-1:0] owed_of(input logic [CNT_W-1:0] rem,
                                               input logic [CNT_W-1:0] lvl);
    return (rem > lvl) ? rem - lvl : '0;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    dout,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + PW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> level == LW'(DEPTH)); // R3
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter
  import i2c_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] rem,
  output logic             armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      rem   <= load_val;
      armed <= 1'b1;
    end else if (dec && rem != '0) begin
      rem <= rem - CNT_W'(1);
    end
  end

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rem == $past(load_val)); // R5
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (rem == '0 && !load) |=> rem == '0); // R5
endmodule

// File: rtl/edge_pulse.sv
module edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic pulse
);
  logic cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign pulse = cond && !cond_q;

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R10
endmodule

// File: rtl/i2c_fifo_events.sv
module i2c_fifo_events
  import i2c_fifo_pkg::*;
#(
  parameter int DEPTH_CODE = 1,
  localparam int DEPTH = 8 << DEPTH_CODE,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [15:0]   cfg_word,
  input  logic [15:0]   cnt_value,
  input  logic          xfer_start,
  input  logic          cpu_tx_push,
  input  logic [7:0]    cpu_tx_data,
  input  logic          cpu_rx_pop,
  output logic [7:0]    cpu_rx_data,
  output logic          rx_underflow,
  input  logic          eng_tx_pop,
  output logic [7:0]    eng_tx_data,
  input  logic          eng_rx_push,
  input  logic [7:0]    eng_rx_data,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          tx_ready_ev,
  output logic          tx_drain_ev,
  output logic          rx_ready_ev,
  output logic          rx_drain_ev,
  output logic [2:0]    depth_code
);
  localparam int TXCLR_BIT = 6;
  localparam int RXCLR_BIT = 14;

  logic [FIELD_W-1:0] tx_field, rx_field;
  logic [THR_W-1:0]   tx_thr, rx_thr;
  logic [CNT_W-1:0]   rem, tx_owed, tx_lvl_w, rx_lvl_w, tx_thr_w, rx_thr_w;
  logic               armed, tx_empty, rx_empty, tx_full, rx_full;
  logic               tx_clr, rx_clr, moved_byte;
  logic [7:0]         rx_head;
  logic [EV_N-1:0]    cond, ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_field <= '0;
      rx_field <= '0;
    end else if (cfg_wr) begin
      tx_field <= cfg_word[5:0];
      rx_field <= cfg_word[13:8];
    end
  end

  assign tx_clr = cfg_wr && cfg_word[TXCLR_BIT];
  assign rx_clr = cfg_wr && cfg_word[RXCLR_BIT];

  byte_fifo #(.DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(cpu_tx_push), .din(cpu_tx_data),
    .pop(eng_tx_pop), .dout(eng_tx_data),
    .level(tx_level), .empty(tx_empty), .full(tx_full));

  byte_fifo #(.DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(eng_rx_push), .din(eng_rx_data),
    .pop(cpu_rx_pop), .dout(rx_head),
    .level(rx_level), .empty(rx_empty), .full(rx_full));

  assign moved_byte = (eng_tx_pop && !tx_empty) || eng_rx_push;

  xfer_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(xfer_start), .load_val(cnt_value),
    .dec(moved_byte), .rem(rem), .armed(armed));

  assign tx_thr   = thr_of(tx_field);
  assign rx_thr   = thr_of(rx_field);
  assign tx_thr_w = CNT_W'(tx_thr);
  assign rx_thr_w = CNT_W'(rx_thr);
  assign tx_lvl_w = CNT_W'(tx_level);
  assign rx_lvl_w = CNT_W'(rx_level);
  assign tx_owed  = owed_of(rem, tx_lvl_w);

  assign cond[EV_TXR] = (tx_lvl_w < tx_thr_w) && (tx_owed >= tx_thr_w);
  assign cond[EV_TXD] = (tx_lvl_w < tx_thr_w) && (tx_owed != '0) && (tx_owed < tx_thr_w);
  assign cond[EV_RXR] = (rx_lvl_w >= rx_thr_w);
  assign cond[EV_RXD] = armed && (rem == '0) && (rx_lvl_w != '0) && (rx_lvl_w < rx_thr_w);

  for (genvar g = 0; g < EV_N; g++) begin : g_ev
    edge_pulse u_pulse (.clk(clk), .rst_n(rst_n), .cond(cond[g]), .pulse(ev[g]));
  end

  assign tx_ready_ev  = ev[EV_TXR];
  assign tx_drain_ev  = ev[EV_TXD];
  assign rx_ready_ev  = ev[EV_RXR];
  assign rx_drain_ev  = ev[EV_RXD];
  assign rx_underflow = cpu_rx_pop && rx_empty;
  assign cpu_rx_data  = rx_empty ? 8'h00 : rx_head;
  assign depth_code   = 3'(DEPTH_CODE);

  AST_TXEV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready_ev && tx_drain_ev)); // R7
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underflow |-> cpu_rx_data == 8'h00); // R4
  AST_RXD_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drain_ev |-> rx_level != '0); // R9
  AST_RXR_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready_ev |-> CNT_W'(rx_level) >= rx_thr_w); // R8
endmodule

// File: tb/i2c_fifo_events_tb_top.sv
module i2c_fifo_events_tb_top;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [15:0] cfg_word = '0;
  logic [15:0] cnt_value = '0;
  logic xfer_start = 1'b0;
  logic cpu_tx_push = 1'b0;
  logic [7:0] cpu_tx_data = '0;
  logic cpu_rx_pop = 1'b0;
  logic [7:0] cpu_rx_data;
  logic rx_underflow;
  logic eng_tx_pop = 1'b0;
  logic [7:0] eng_tx_data;
  logic eng_rx_push = 1'b0;
  logic [7:0] eng_rx_data = '0;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_ready_ev, tx_drain_ev, rx_ready_ev, rx_drain_ev;
  logic [2:0] depth_code;

  int n_checks = 0;
  int n_err = 0;
  int n_txr = 0, n_txd = 0, n_rxr = 0, n_rxd = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_fifo_events #(.DEPTH_CODE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .cnt_value(cnt_value), .xfer_start(xfer_start),
    .cpu_tx_push(cpu_tx_push), .cpu_tx_data(cpu_tx_data),
    .cpu_rx_pop(cpu_rx_pop), .cpu_rx_data(cpu_rx_data), .rx_underflow(rx_underflow),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_ready_ev(tx_ready_ev), .tx_drain_ev(tx_drain_ev),
    .rx_ready_ev(rx_ready_ev), .rx_drain_ev(rx_drain_ev),
    .depth_code(depth_code));

  // pulse counters, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      n_txr = n_txr + int'(tx_ready_ev);
      n_txd = n_txd + int'(tx_drain_ev);
      n_rxr = n_rxr + int'(rx_ready_ev);
      n_rxd = n_rxd + int'(rx_drain_ev);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic zero_counts();
    n_txr = 0; n_txd = 0; n_rxr = 0; n_rxd = 0;
  endtask

  task automatic cfg(input logic [15:0] w);
    cfg_wr = 1'b1; cfg_word = w;
    cyc();
    cfg_wr = 1'b0; cfg_word = '0;
  endtask

  task automatic start(input logic [15:0] n);
    xfer_start = 1'b1; cnt_value = n;
    cyc();
    xfer_start = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] b);
    cpu_tx_push = 1'b1; cpu_tx_data = b;
    cyc();
    cpu_tx_push = 1'b0;
  endtask

  task automatic tx_pop();
    eng_tx_pop = 1'b1;
    cyc();
    eng_tx_pop = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    eng_rx_push = 1'b1; eng_rx_data = b;
    cyc();
    eng_rx_push = 1'b0;
  endtask

  task automatic rx_pop();
    cpu_rx_pop = 1'b1;
    cyc();
    cpu_rx_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 tx_level", int'(tx_level), 0);
    chk("R1 rx_level", int'(rx_level), 0);
    chk("R1 events", int'({tx_ready_ev, tx_drain_ev, rx_ready_ev, rx_drain_ev}), 0);
    chk("R1 rx_underflow", int'(rx_underflow), 0);
    chk("R11 depth_code", int'(depth_code), 1);
  endtask

  task automatic t_tx_flow();
    cfg(16'h0303);            // tx threshold 4, rx threshold 4
    start(16'd10);
    chk("R6 ready on start", int'(tx_ready_ev), 1);
    chk("R7 no drain on start", int'(tx_drain_ev), 0);
    cyc();
    chk("R10 single cycle pulse", int'(tx_ready_ev), 0);
    for (int k = 0; k < 4; k++) tx_push(8'hA0 + 8'(k));
    chk("R3 tx level after 4 pushes", int'(tx_level), 4);
    zero_counts();
    for (int k = 0; k < 4; k++) begin
      chk("R3 tx order", int'(eng_tx_data), 32'hA0 + k);
      tx_pop();
    end
    chk("R6 one ready pulse with 6 owed", n_txr, 1);
    chk("R7 no drain with 6 owed", n_txd, 0);
    for (int k = 0; k < 4; k++) tx_push(8'hB0 + 8'(k));
    zero_counts();
    for (int k = 0; k < 4; k++) tx_pop();
    chk("R7 one drain pulse with 2 owed", n_txd, 1);
    chk("R6 no ready with 2 owed", n_txr, 0);
    zero_counts();
    tx_push(8'hC0); tx_push(8'hC1);
    tx_pop(); tx_pop();
    chk("R7 silent once all queued", n_txr + n_txd, 0);
  endtask

  task automatic t_rx_flow();
    cfg(16'h4203);            // rx threshold 3, clear rx
    start(16'd5);
    zero_counts();
    for (int k = 0; k < 3; k++) rx_push(8'hD0 + 8'(k));
    chk("R8 ready at threshold", int'(rx_ready_ev), 1);
    chk("R8 one ready pulse", n_rxr, 1);
    for (int k = 0; k < 3; k++) begin
      chk("R4 rx head byte", int'(cpu_rx_data), 32'hD0 + k);
      rx_pop();
    end
    zero_counts();
    rx_push(8'hE0); rx_push(8'hE1);
    chk("R9 drain on last byte", int'(rx_drain_ev), 1);
    chk("R8 no ready below threshold", n_rxr, 0);
    rx_pop(); rx_pop();
    cpu_rx_pop = 1'b1;
    #1;
    chk("R4 underflow flag", int'(rx_underflow), 1);
    chk("R4 empty read value", int'(cpu_rx_data), 0);
    cyc();
    cpu_rx_pop = 1'b0;
    chk("R4 level after empty read", int'(rx_level), 0);
  endtask

  task automatic t_clear();
    tx_push(8'h11); tx_push(8'h12); tx_push(8'h13);
    chk("R3 tx level 3", int'(tx_level), 3);
    cfg(16'h0243);            // clear tx
    chk("R2 tx clear", int'(tx_level), 0);
    rx_push(8'h21); rx_push(8'h22);
    cfg(16'h4203);            // clear rx
    chk("R2 rx clear", int'(rx_level), 0);
  endtask

  task automatic t_overflow();
    start(16'd0);
    zero_counts();
    for (int k = 0; k < 20; k++) tx_push(8'h40 + 8'(k));
    chk("R3 full level", int'(tx_level), 16);
    chk("R3 oldest kept", int'(eng_tx_data), 32'h40);
    tx_pop();
    chk("R5 no events with zero count", n_txr + n_txd, 0);
    cfg(16'h0243);
  endtask

  task automatic t_short_count();
    cfg(16'h0203);            // tx threshold 4
    start(16'd3);
    chk("R5 short count drains", int'(tx_drain_ev), 1);
    chk("R5 short count not ready", int'(tx_ready_ev), 0);
    cfg(16'h0201);            // tx threshold 2
    chk("R2 lower threshold gives ready", int'(tx_ready_ev), 1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_tx_flow();
    t_rx_flow();
    t_clear();
    t_overflow();
    t_short_count();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule